// File: doc/BRIEF.md
# Newton-Raphson Reciprocal Integer Divider

This block divides one unsigned 32-bit integer by another over a short run of multiply cycles. It does not retire one quotient bit per cycle. A start pulse captures both operands. The divisor is then shifted left until its top bit is set, and a small table built from gates supplies a 4-bit first guess of its reciprocal. Newton-Raphson passes on one shared, fixed-latency multiplier refine that guess. The refined reciprocal times the dividend gives a raw quotient. The remainder is then formed with the same multiplier and a subtractor, and a short correction loop makes both results exact.

The result appears with a single-cycle done pulse. The quotient and remainder outputs hold their values until the next result. A zero divisor skips the arithmetic: it returns a saturated quotient, passes the dividend through as the remainder, and raises a flag.

Top module: `nr_divider`

## Requirements
- R1: Before any multiply, the captured divisor is shifted left by its leading-zero count, so its bit 31 is 1. The same count is kept and sets the final right shift of the dividend-times-reciprocal product.
- R2: The first reciprocal guess comes from a 64-entry table of 4-bit values, computed by logic and indexed by bits 31..26 of the normalized divisor. Entry i holds round(1024/(2i+1)) clamped to 15, so every reachable entry has its top bit set. Every index range gives exact results.
- R3: Refinement runs x' = x*(2 - d*x) exactly four times. The reciprocal operand is cut to its top 4, 8 and 16 bits in the first three passes and used at full width in the last pass. Full-width operands then give exact results.
- R4: For a non-zero divisor, quot_o equals dividend/divisor and rem_o equals dividend%divisor, with rem_o below the divisor.
- R5: The remainder is dividend minus quotient times divisor. The correction loop subtracts 1 from the quotient while the remainder is negative and adds 1 while the remainder is at least the divisor, one step per cycle, and takes fewer than 16 steps.
- R6: A zero divisor sets div_zero_o to 1, quot_o to all ones and rem_o to the dividend, with done_o high in the first cycle after the start is captured.
- R7: done_o is high for exactly one cycle per accepted start. busy_o is high from the cycle after capture through the done cycle, and low again in the cycle after it.
- R8: A start_i pulse while busy_o is high is ignored, and the result belongs to the operands captured first.
- R9: A division by a non-zero divisor clears div_zero_o left over from an earlier divide by zero.
- R10: After reset, busy_o, done_o and div_zero_o are 0, and quot_o and rem_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures the operands when the block is idle |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 32 | Unsigned divisor |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle pulse when results are valid |
| quot_o | output | 32 | Quotient, held until the next result |
| rem_o | output | 32 | Remainder, held until the next result |
| div_zero_o | output | 1 | The last result came from a zero divisor |

## Verification
Some properties are checked on every cycle, whatever the operands:
- the normalized divisor has its top bit set whenever a multiply is issued;
- exactly four refinement passes run before the quotient multiply;
- the multiplier is never restarted while it is still running;
- the correction loop stays under its step bound;
- every non-zero result has a remainder below the captured divisor;
- every zero-divisor result is saturated;
- the done pulse lasts one cycle.

Other behaviour only the bench's scenarios can show:
- exact agreement with integer division for random and edge-case operands;
- results for divisors in every seed-table index range;
- results for powers of two, a divisor of 1, equal operands and a dividend below the divisor;
- that a start pulse sent mid-division leaves the result unchanged.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_NORM, S_ISSUE, S_WAIT, S_FIX, S_DONE
  } div_state_e;

  // which product the shared multiplier is forming
  typedef enum logic [1:0] {
    OP_DX,  // d * x
    OP_XE,  // x * (2 - d*x)
    OP_Q,   // dividend * x
    OP_R    // quotient * divisor
  } mul_op_e;
endpackage

// File: rtl/nr_lzc.sv
module nr_lzc #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/nr_seed.sv
module nr_seed #(
  parameter int unsigned W      = 32,
  parameter int unsigned SEED_W = 4,
  localparam int unsigned IDX_W = SEED_W + 2,
  localparam int unsigned XW    = W + 2
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [XW-1:0]    x0_o
);
  localparam int unsigned NENT = 1 << IDX_W;
  localparam int unsigned SMAX = (1 << SEED_W) - 1;

  logic [SEED_W-1:0] tbl [NENT];
  logic [SEED_W-1:0] seed;

  // seed = round(2^(IDX_W+SEED_W) / (2i+1)), clamped
  for (genvar i = 0; i < NENT; i++) begin : g_ent
    localparam int unsigned RAW = ((1 << (IDX_W + SEED_W + 1)) / (2 * i + 1) + 1) / 2;
    assign tbl[i] = (RAW > SMAX) ? SEED_W'(SMAX) : SEED_W'(RAW);
  end

  assign seed = tbl[idx_i];
  assign x0_o = XW'(seed) << (W - SEED_W + 1);

  always_comb begin
    if (idx_i[IDX_W-1]) AST_SEED_MSB: assert (seed[SEED_W-1]); // R2
  end
endmodule

// File: rtl/nr_mul.sv
module nr_mul #(
  parameter int unsigned XW  = 34,
  parameter int unsigned LAT = 2,
  localparam int unsigned PW = 2 * XW,
  localparam int unsigned CW = $clog2(LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [XW-1:0] a_i,
  input  logic [XW-1:0] b_i,
  output logic [PW-1:0] p_o,
  output logic          valid_o
);
  logic [XW-1:0] a_q, b_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
      cnt_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (go_i) begin
        a_q <= a_i;
        b_q <= b_i;
        cnt_q <= CW'(LAT);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        valid_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign p_o = PW'(a_q) * PW'(b_q);
  assign valid_o = valid_q;

  AST_MUL_GO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> cnt_q == '0); // R3
  AST_MUL_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> !valid_o); // R3
endmodule

// File: rtl/nr_divider.sv
module nr_divider
  import nr_div_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned SEED_W  = 4,
  parameter int unsigned MUL_LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         div_zero_o
);
  localparam int unsigned XW      = W + 2;
  localparam int unsigned PW      = 2 * XW;
  localparam int unsigned RW      = W + 3;
  localparam int unsigned SW      = $clog2(W);
  localparam int unsigned IDX_W   = SEED_W + 2;
  localparam int unsigned ITERS   = $clog2(W / SEED_W) + 1;
  localparam int unsigned IW      = $clog2(ITERS + 1);
  localparam int unsigned FIX_MAX = 16;
  localparam int unsigned FW      = $clog2(FIX_MAX + 1);
  localparam int unsigned QSW     = $clog2(2 * W + 1);

  div_state_e state_q;
  mul_op_e    op_q;

  logic [W-1:0]         a_q, b_q, d_q;
  logic [SW-1:0]        sh_q;
  logic [XW-1:0]        x_q, e_q;
  logic [IW-1:0]        it_q;
  logic [W-1:0]         q_q;
  logic signed [RW-1:0] r_q;
  logic [FW-1:0]        fix_q;
  logic [W-1:0]         quot_q, rem_q;
  logic                 dz_q;

  // normalization and seed
  logic [SW-1:0] lz;
  logic [W-1:0]  d_norm;
  logic [XW-1:0] x_seed;

  nr_lzc #(.W(W)) u_lzc (.val_i(b_q), .cnt_o(lz));
  assign d_norm = b_q << lz;

  nr_seed #(.W(W), .SEED_W(SEED_W)) u_seed (
    .idx_i(d_norm[W-1 -: IDX_W]),
    .x0_o (x_seed)
  );

  // reciprocal operand trimmed to the precision of the current pass
  logic [XW-1:0] x_m;
  int            low_bits;
  always_comb begin
    low_bits = W + 1 - (SEED_W << it_q);
    if (int'(it_q) < ITERS - 1 && low_bits > 0)
      x_m = x_q & ~((XW'(1) << low_bits) - XW'(1));
    else
      x_m = x_q;
  end

  // shared multiplier
  logic          mul_go, mul_valid;
  logic [XW-1:0] mul_a, mul_b;
  logic [PW-1:0] mul_p;

  always_comb begin
    unique case (op_q)
      OP_DX:   begin mul_a = XW'(d_q); mul_b = x_m;        end
      OP_XE:   begin mul_a = x_m;      mul_b = e_q;        end
      OP_Q:    begin mul_a = XW'(a_q); mul_b = x_q;        end
      default: begin mul_a = XW'(q_q); mul_b = XW'(b_q);   end
    endcase
  end
  assign mul_go = (state_q == S_ISSUE);

  nr_mul #(.XW(XW), .LAT(MUL_LAT)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (mul_go),
    .a_i    (mul_a),
    .b_i    (mul_b),
    .p_o    (mul_p),
    .valid_o(mul_valid)
  );

  logic [PW-1:0]        e_full;
  logic [QSW-1:0]       q_shift;
  logic signed [RW-1:0] r_first;
  logic signed [RW-1:0] b_ext;

  assign e_full  = (PW'(1) << (2 * W + 1)) - mul_p;
  assign q_shift = QSW'(2 * W) - QSW'(sh_q);
  assign r_first = $signed({3'b000, a_q}) - $signed(mul_p[RW-1:0]);
  assign b_ext   = $signed({3'b000, b_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_DX;
      a_q     <= '0;
      b_q     <= '0;
      d_q     <= '0;
      sh_q    <= '0;
      x_q     <= '0;
      e_q     <= '0;
      it_q    <= '0;
      q_q     <= '0;
      r_q     <= '0;
      fix_q   <= '0;
      quot_q  <= '0;
      rem_q   <= '0;
      dz_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          a_q <= dividend_i;
          b_q <= divisor_i;
          if (divisor_i == '0) begin
            quot_q  <= '1;
            rem_q   <= dividend_i;
            dz_q    <= 1'b1;
            state_q <= S_DONE;
          end else begin
            state_q <= S_NORM;
          end
        end
        S_NORM: begin
          d_q     <= d_norm;
          sh_q    <= lz;
          x_q     <= x_seed;
          it_q    <= '0;
          op_q    <= OP_DX;
          fix_q   <= '0;
          state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (mul_valid) begin
          unique case (op_q)
            OP_DX: begin
              e_q     <= XW'(e_full >> W);
              op_q    <= OP_XE;
              state_q <= S_ISSUE;
            end
            OP_XE: begin
              x_q     <= XW'(mul_p >> W);
              it_q    <= it_q + 1'b1;
              op_q    <= (int'(it_q) == ITERS - 1) ? OP_Q : OP_DX;
              state_q <= S_ISSUE;
            end
            OP_Q: begin
              q_q     <= W'(mul_p >> q_shift);
              op_q    <= OP_R;
              state_q <= S_ISSUE;
            end
            default: begin
              r_q     <= r_first;
              state_q <= S_FIX;
            end
          endcase
        end
        S_FIX: begin
          fix_q <= fix_q + 1'b1;
          if (r_q < 0) begin
            q_q <= q_q - 1'b1;
            r_q <= r_q + b_ext;
          end else if (r_q >= b_ext) begin
            q_q <= q_q + 1'b1;
            r_q <= r_q - b_ext;
          end else begin
            quot_q  <= q_q;
            rem_q   <= r_q[W-1:0];
            dz_q    <= 1'b0;
            state_q <= S_DONE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign quot_o     = quot_q;
  assign rem_o      = rem_q;
  assign div_zero_o = dz_q;

  AST_NORM_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ISSUE) |-> d_q[W-1]); // R1
  AST_ITER_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ISSUE && op_q == OP_Q) |-> (int'(it_q) == ITERS)); // R3
  AST_REM_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> (rem_o < b_q)); // R4
  AST_FIX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FIX) |-> (fix_q < FW'(FIX_MAX))); // R5
  AST_ZDIV_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_zero_o) |-> (quot_o == '1 && rem_o == a_q)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R7
  AST_HOLD_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(a_q) && $stable(b_q))); // R8
endmodule

// File: tb/sim_nr_divider.sv
module sim_nr_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dvd = '0, dvs = '0;
  logic        busy, done, dz;
  logic [31:0] quot, rem;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] lfsr = 32'h1BADF00D;

  always #4 clk = ~clk;

  nr_divider u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done), .quot_o(quot), .rem_o(rem),
    .div_zero_o(dz)
  );

  localparam int NV = 16;
  localparam logic [63:0] VEC [NV] = '{
    {32'd100,        32'd7},
    {32'd1,          32'd1},
    {32'd0,          32'd5},
    {32'd5,          32'd1},
    {32'd12345,      32'd12345},
    {32'd3,          32'd10},
    {32'hFFFFFFFF,   32'd1},
    {32'hFFFFFFFF,   32'hFFFFFFFF},
    {32'hFFFFFFFF,   32'd2},
    {32'h80000000,   32'h80000000},
    {32'hFFFFFFFE,   32'hFFFFFFFF},
    {32'hDEADBEEF,   32'd3},
    {32'hFFFFFFFF,   32'h00010001},
    {32'h7FFFFFFF,   32'h0000FFFF},
    {32'd1000000007, 32'd97},
    {32'hC0000000,   32'h40000001}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // start at a negedge, wait for done, sample at negedges
  task automatic divide(input logic [31:0] a, input logic [31:0] b, output int cyc);
    @(negedge clk);
    dvd = a; dvs = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic div_check(input logic [31:0] a, input logic [31:0] b, input string tag);
    int cyc;
    divide(a, b, cyc);
    check(done, {tag, " done"}, 32'(done), 32'd1);
    check(quot == a / b, {tag, " quot"}, quot, a / b);
    check(rem == a % b, {tag, " rem"}, rem, a % b);
    check(!dz, {tag, " R9 dz"}, 32'(dz), 32'd0);
    @(negedge clk);
    check(!done && !busy, "R7 done one cycle, idle after", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !dz, "R10 flags", {29'd0, busy, done, dz}, 32'd0);
    check(quot == 0 && rem == 0, "R10 results", quot | rem, 32'd0);
    rst_n = 1'b1;

    // table of vectors, R4
    for (int i = 0; i < NV; i++) div_check(VEC[i][63:32], VEC[i][31:0], "R4 table");

    // R5 corner cases: equal operands, dividend below divisor, divisor of 1
    div_check(32'h89ABCDEF, 32'h89ABCDEF, "R5 equal");
    div_check(32'h00001234, 32'h00012345, "R5 small dividend");
    div_check(32'hFEDCBA98, 32'd1, "R5 divisor one");

    // R1 powers of two: every shift count
    for (int k = 0; k < 32; k++) div_check(next_rand(), 32'd1 << k, "R1 pow2");

    // R2 every reachable seed index
    for (int i = 32; i < 64; i++) begin
      b = (32'(i) << 26) | (next_rand() & 32'h03FFFFFF);
      div_check(32'hFFFFFFFF, b, "R2 seed range");
      div_check(next_rand(), b >> (i % 20), "R2 seed shifted");
    end

    // R3 full-width random operands
    for (int i = 0; i < 40; i++) begin
      a = next_rand();
      b = next_rand() >> (i % 31);
      if (b == 0) b = 32'd3;
      div_check(a, b, "R3 random");
    end

    // R6 divide by zero
    divide(32'h13572468, 32'd0, cyc);
    check(cyc == 1, "R6 latency", 32'(cyc), 32'd1);
    check(dz, "R6 flag", 32'(dz), 32'd1);
    check(quot == 32'hFFFFFFFF, "R6 quot", quot, 32'hFFFFFFFF);
    check(rem == 32'h13572468, "R6 rem", rem, 32'h13572468);
    @(negedge clk);
    check(!done, "R7 dz done one cycle", 32'(done), 32'd0);

    // R9 flag cleared by a normal divide
    div_check(32'd77, 32'd11, "R9 after zero");

    // R8 start while busy is ignored
    @(negedge clk);
    dvd = 32'd1000; dvs = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy, "R7 busy during divide", 32'(busy), 32'd1);
    dvd = 32'd999999; dvs = 32'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    check(quot == 32'd142, "R8 quot of first operands", quot, 32'd142);
    check(rem == 32'd6, "R8 rem of first operands", rem, 32'd6);
    @(negedge clk);
    check(!busy, "R8 idle after, no second run", 32'(busy), 32'd0);
    repeat (5) @(negedge clk);
    check(!busy && !done, "R8 ignored start never ran", {30'd0, busy, done}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule